// File: doc/BRIEF.md
# Link Power-Mode HOLD Sequencer

This block sits in a serial storage link layer, between the upper layer's 32-bit transmit words and the scrambler and encoder. In normal operation it forwards data words one cycle late. When the transmit FIFO is about to run dry or the receive FIFO is about to fill, it replaces the outgoing word with the HOLD primitive and marks it as a primitive.

It also takes the link into one of two low-power modes, partial or slumber. When the upper layer asks for a mode, the block first sends an unbroken run of at least `MIN_HOLDS` HOLD primitives, so that the far end sees the request. Only then does it enter the requested mode and acknowledge it. A wake indication from the PHY brings the link back through a one-cycle wake state to normal operation. A reserved request code is flagged to the upper layer as an error.

State codes on `pm_state`: 0 run, 1 hold burst, 2 partial, 3 slumber, 4 wake.

Top module: `lpm_hold_seq`

## Requirements
- R1: While reset is asserted and after its release, `pm_state` is 0, `tx_word` is 0, and `tx_prim`, `pm_ack` and `pm_err` are 0.
- R2: In the run state with neither pressure flag set, `tx_word` shows `tx_data` one cycle after a cycle with `tx_data_vld` high, with `tx_prim` 0. One cycle after a cycle with `tx_data_vld` low, it shows 0.
- R3: In the run state, if `txf_low` or `rxf_high` is high, then on the next cycle `tx_word` is the HOLD word (default 32'h7B4A4A4A) and `tx_prim` is 1. This takes precedence over valid data. Whenever `tx_prim` is 1, `tx_word` is the HOLD word.
- R4: Data is forwarded again on the cycle after both pressure flags go low.
- R5: In the run state, `pm_req` 2'b01 (partial) or 2'b10 (slumber) moves the block to state 1 on the next cycle. It then sends exactly `MIN_HOLDS` (default 16) consecutive HOLD primitives, starting on that same cycle.
- R6: The cycle after the last HOLD of the burst, `pm_state` is 2 for partial or 3 for slumber. In that state `pm_ack` is 1, `tx_prim` is 0 and `tx_word` is 0.
- R7: Changes to `pm_req` during the HOLD burst are ignored. The mode requested on entry is the one reached, and the burst length does not change.
- R8: In partial or slumber, `phy_wake` high moves `pm_state` to 4 on the next cycle, and to 0 the cycle after that. In the low-power states, `pm_req` and the pressure flags are ignored: the state holds and no HOLD is sent.
- R9: `phy_wake` in the run state has no effect: the state stays 0 and data is forwarded.
- R10: `pm_req` 2'b11 in the run state raises `pm_err` on the next cycle and leaves the state at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_req | input | 2 | Power request: 00 none, 01 partial, 10 slumber, 11 reserved |
| tx_data | input | 32 | Data word from upper layer |
| tx_data_vld | input | 1 | `tx_data` is valid |
| txf_low | input | 1 | Transmit FIFO near-empty |
| rxf_high | input | 1 | Receive FIFO near-full |
| phy_wake | input | 1 | Wake indication from the PHY |
| tx_word | output | 32 | Outgoing transmit word |
| tx_prim | output | 1 | `tx_word` is a primitive (HOLD) |
| pm_state | output | 3 | Current power state code |
| pm_ack | output | 1 | A low-power mode is in force |
| pm_err | output | 1 | Reserved request seen |

## Verification
The word outputs and `pm_err` are registered from inputs seen one edge earlier, so every data, HOLD and error result is due one cycle after its stimulus. `pm_state` moves on that same edge. `pm_ack` follows the state with no extra delay. The bench applies inputs just after an edge and reads results just after the next edge. It counts the HOLD burst one cycle at a time, so both the first and the last primitive of the burst are checked on the exact cycle they are due.

// File: rtl/lpm_hold_seq.sv
module lpm_hold_seq #(
  parameter int unsigned DW        = 32,
  parameter logic [DW-1:0] HOLD_WORD = 'h7B4A4A4A,
  parameter int unsigned MIN_HOLDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pm_req,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_data_vld,
  input  logic          txf_low,
  input  logic          rxf_high,
  input  logic          phy_wake,
  output logic [DW-1:0] tx_word,
  output logic          tx_prim,
  output logic [2:0]    pm_state,
  output logic          pm_ack,
  output logic          pm_err
);
  localparam int CW = $clog2(MIN_HOLDS + 1);

  typedef enum logic [2:0] {
    ST_RUN = 3'd0, ST_HOLDOFF = 3'd1, ST_PART = 3'd2, ST_SLUM = 3'd3, ST_WAKE = 3'd4
  } st_t;

  st_t st, nx;
  logic [CW-1:0] cnt;
  logic tgt_slum;

  wire pressure = txf_low | rxf_high;
  wire lp_req   = (pm_req == 2'b01) || (pm_req == 2'b10);

  always_comb begin
    nx = st;
    case (st)
      ST_RUN:          if (lp_req) nx = ST_HOLDOFF;
      ST_HOLDOFF:      if (cnt == CW'(1)) nx = tgt_slum ? ST_SLUM : ST_PART;
      ST_PART, ST_SLUM: if (phy_wake) nx = ST_WAKE;
      ST_WAKE:         nx = ST_RUN;
      default:         nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      cnt      <= '0;
      tgt_slum <= 1'b0;
      tx_word  <= '0;
      tx_prim  <= 1'b0;
      pm_err   <= 1'b0;
    end else begin
      st     <= nx;
      pm_err <= (st == ST_RUN) && (pm_req == 2'b11);
      if (st == ST_RUN && nx == ST_HOLDOFF) begin
        cnt      <= CW'(MIN_HOLDS);
        tgt_slum <= pm_req[1];
      end else if (st == ST_HOLDOFF) begin
        cnt <= cnt - CW'(1);
      end
      if (nx == ST_HOLDOFF || (st == ST_RUN && nx == ST_RUN && pressure)) begin
        tx_word <= HOLD_WORD;
        tx_prim <= 1'b1;
      end else if (st == ST_RUN && nx == ST_RUN && tx_data_vld) begin
        tx_word <= tx_data;
        tx_prim <= 1'b0;
      end else begin
        tx_word <= '0;
        tx_prim <= 1'b0;
      end
    end
  end

  assign pm_state = st;
  assign pm_ack   = (st == ST_PART) || (st == ST_SLUM);
endmodule

// File: rtl/lpm_hold_seq_chk.sv
module lpm_hold_seq_chk #(
  parameter int unsigned DW        = 32,
  parameter logic [DW-1:0] HOLD_WORD = 'h7B4A4A4A,
  parameter int unsigned MIN_HOLDS = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    pm_req,
  input logic          txf_low,
  input logic          rxf_high,
  input logic          phy_wake,
  input logic [DW-1:0] tx_word,
  input logic          tx_prim,
  input logic [2:0]    pm_state,
  input logic          pm_ack,
  input logic          pm_err
);
  logic [15:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (tx_prim) run <= (run == 16'hFFFF) ? run : run + 16'd1;
    else run <= '0;
  end

  wire in_lp = (pm_state == 3'd2) || (pm_state == 3'd3);

  a_r3_prim_word: assert property (@(posedge clk) disable iff (!rst_n)
    tx_prim |-> tx_word == HOLD_WORD);
  a_r3_pressure_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd0 && (txf_low || rxf_high)) |=> tx_prim);
  a_r5_min_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pm_ack) |-> run >= 16'(MIN_HOLDS));
  a_r6_quiet_lp: assert property (@(posedge clk) disable iff (!rst_n)
    pm_ack |-> (!tx_prim && tx_word == '0));
  a_r8_wake_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lp && phy_wake) |=> pm_state == 3'd4);
  a_r8_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    pm_state == 3'd4 |=> pm_state == 3'd0);
  a_r10_err_state: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd0 && pm_req == 2'b11) |=> (pm_err && pm_state == 3'd0));
endmodule

bind lpm_hold_seq lpm_hold_seq_chk #(.DW(DW), .HOLD_WORD(HOLD_WORD), .MIN_HOLDS(MIN_HOLDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pm_req(pm_req), .txf_low(txf_low), .rxf_high(rxf_high),
  .phy_wake(phy_wake), .tx_word(tx_word), .tx_prim(tx_prim), .pm_state(pm_state),
  .pm_ack(pm_ack), .pm_err(pm_err)
);

// File: tb/lpm_hold_seq_tb_top.sv
`timescale 1ns/1ps
module lpm_hold_seq_tb_top;
  localparam logic [31:0] HOLD = 32'h7B4A4A4A;
  localparam int NH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pm_req = 2'b00;
  logic [31:0] tx_data = '0;
  logic tx_data_vld = 1'b0, txf_low = 1'b0, rxf_high = 1'b0, phy_wake = 1'b0;
  logic [31:0] tx_word;
  logic tx_prim, pm_ack, pm_err;
  logic [2:0] pm_state;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lpm_hold_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pm_req(pm_req), .tx_data(tx_data), .tx_data_vld(tx_data_vld),
    .txf_low(txf_low), .rxf_high(rxf_high), .phy_wake(phy_wake), .tx_word(tx_word),
    .tx_prim(tx_prim), .pm_state(pm_state), .pm_ack(pm_ack), .pm_err(pm_err)
  );

  // {data[67:36], vld[35], txf_low[34], rxf_high[33], exp_prim[32], exp_word[31:0]}
  localparam logic [67:0] VEC [8] = '{
    {32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1234_5678},
    {32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
    {32'hCAFE_0001, 1'b1, 1'b1, 1'b0, 1'b1, HOLD},
    {32'hCAFE_0002, 1'b1, 1'b0, 1'b1, 1'b1, HOLD},
    {32'hCAFE_0003, 1'b1, 1'b1, 1'b1, 1'b1, HOLD},
    {32'h0BAD_F00D, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0BAD_F00D},
    {32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF},
    {32'h5555_AAAA, 1'b0, 1'b0, 1'b1, 1'b1, HOLD}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic enter_lp(input logic [1:0] req, input logic [2:0] st_exp, input bit flip);
    int holds = 0;
    pm_req = req;
    step();
    chk("R5 enter", 32'(pm_state), 32'd1);
    pm_req = flip ? (req ^ 2'b11) : 2'b00;
    for (int k = 0; k < NH; k++) begin
      if (tx_prim === 1'b1 && tx_word === HOLD && pm_state === 3'd1) holds++;
      if (k < NH - 1) step();
    end
    chk("R5 burst", 32'(holds), 32'(NH));
    pm_req = 2'b00;
    step();
    chk(flip ? "R7 target" : "R6 state", 32'(pm_state), 32'(st_exp));
    chk("R6 ack", {pm_ack, tx_prim, tx_word[29:0]}, {1'b1, 31'd0});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1 state", 32'(pm_state), 32'd0);
    chk("R1 out", {tx_word[28:0], tx_prim, pm_ack, pm_err}, 32'd0);
    rst_n = 1'b1;
    step();
    chk("R1 after", {tx_word[28:0], tx_prim, pm_ack, pm_err}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      tx_data = VEC[i][67:36]; tx_data_vld = VEC[i][35];
      txf_low = VEC[i][34]; rxf_high = VEC[i][33];
      step();
      chk((VEC[i][34] | VEC[i][33]) ? "R3" : (i == 5 ? "R4" : "R2"), tx_word, VEC[i][31:0]);
      chk((VEC[i][34] | VEC[i][33]) ? "R3 prim" : "R2 prim", 32'(tx_prim), 32'(VEC[i][32]));
    end
    txf_low = 0; rxf_high = 0;
    tx_data = 32'h0000_0042; tx_data_vld = 1;
    step();
    chk("R4 resume", tx_word, 32'h0000_0042);

    phy_wake = 1; tx_data = 32'h0000_0099;
    step();
    chk("R9 state", 32'(pm_state), 32'd0);
    chk("R9 data", tx_word, 32'h0000_0099);
    phy_wake = 0; tx_data_vld = 0;

    pm_req = 2'b11;
    step();
    chk("R10 err", 32'(pm_err), 32'd1);
    chk("R10 state", 32'(pm_state), 32'd0);
    pm_req = 2'b00;
    step();
    chk("R10 clear", 32'(pm_err), 32'd0);

    enter_lp(2'b01, 3'd2, 0);
    pm_req = 2'b10; txf_low = 1; rxf_high = 1;
    step();
    chk("R8 ignore state", 32'(pm_state), 32'd2);
    chk("R8 ignore prim", 32'(tx_prim), 32'd0);
    pm_req = 2'b00; txf_low = 0; rxf_high = 0;
    phy_wake = 1;
    step();
    chk("R8 wake", 32'(pm_state), 32'd4);
    phy_wake = 0;
    step();
    chk("R8 run", 32'(pm_state), 32'd0);

    enter_lp(2'b10, 3'd3, 0);
    phy_wake = 1;
    step();
    chk("R8 wake slumber", 32'(pm_state), 32'd4);
    phy_wake = 0;
    step();
    chk("R8 run slumber", 32'(pm_state), 32'd0);

    enter_lp(2'b10, 3'd3, 1);
    phy_wake = 1; step(); phy_wake = 0; step();
    chk("R8 back", 32'(pm_state), 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule